// File: doc/BRIEF.md
# Slot-Masked TDM Serial Receiver

This block takes one time-division-multiplexed serial audio stream and turns it into parallel words. A frame sync pulse marks the first bit of slot 0. Each slot is `SLOT_W` bits long and arrives most significant bit first. Up to 32 slots make a frame. A 32-bit slot mask picks which slots are kept. A kept slot's word goes into a receive data register and raises a receive-full flag. A masked slot is shifted in and thrown away.

The block runs on one system clock. Serial bits are taken only on cycles where `bit_stb` is high, one strobe per bit-clock sampling edge. A small register bus reaches four registers:

| Address | Register |
|---|---|
| 0 | Slot mask |
| 1 | Frame control |
| 2 | Received word |
| 3 | Status |

Mask and control writes go into a pending copy. The receiver takes that copy only when the next frame starts, so a write never disturbs the frame in progress. A read of the pending copy returns the value written.

In single-slot mode, each frame sync starts one slot only, and mask bit 0 decides whether it is kept. In multi-slot mode, the control register sets how many slots a frame holds.

Top module: `tdm_rx`

## Requirements
- R1: After reset, address 0 reads 0xFFFFFFFF, address 1 reads 0x0000011F (multi-slot mode, 32 slots), and addresses 2 and 3 read 0.
- R2: When mask bit N is 1, the SLOT_W bits of slot N (first bit is the MSB) appear zero-extended at address 2 on the strobe of the slot's last bit, and status bit 0 (full) is set.
- R3: When mask bit N is 0, slot N leaves address 2 and the full flag unchanged.
- R4: The mask used for a frame is the value pending at the strobe that carries the frame sync. A write during a frame affects only later frames.
- R5: A read of address 0 returns the last value written, even before that value is in use.
- R6: A read of address 2 clears the full flag. If a kept word lands in the same cycle as that read, the read returns the old word and the full flag stays set.
- R7: If a kept word lands while the full flag is set and address 2 is not being read, status bit 1 (overrun) is set and the new word replaces the old one. A read of address 3 clears overrun but not full.
- R8: Control bits [4:0] hold the slot count minus one. Bits that arrive after the last slot and before the next frame sync are ignored.
- R9: With control bit 8 at 0 (single-slot mode), only slot 0 of each frame is received, under mask bit 0, whatever the slot count field holds.
- R10: A control write during a frame affects only later frames.
- R11: A frame starts when fsync is 1 on a strobe. That bit is the MSB of slot 0. A frame sync in the middle of a frame drops any partial slot and restarts at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_stb | input | 1 | One-cycle strobe at each bit sampling point |
| fsync | input | 1 | Frame sync, sampled on bit_stb |
| sdata | input | 1 | Serial data, sampled on bit_stb |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| rx_full | output | 1 | A kept word is waiting |
| rx_ovr | output | 1 | A kept word overwrote an unread one |

## Verification
The bench sweeps several mask patterns over a short frame and checks every slot.

- If the mask were indexed off by one, or read with the bits reversed, the wrong slots would set the flag.
- If the mask or control were applied the moment they are written, the frame that was cut into would gain or lose slots.
- If the slot counter ran past its limit, or ignored a mid-frame frame sync, the trailing bits would land as extra words or the slot alignment would be wrong.
- If the flags gave priority to the wrong event, a read in the same cycle as a store would lose the new word, or a read with no overwrite would report a false overrun.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
  localparam int MAX_SLOTS  = 32;
  localparam int SLOT_IDX_W = $clog2(MAX_SLOTS);
  localparam int BUS_W      = 32;

  localparam logic [1:0] A_MASK = 2'd0;
  localparam logic [1:0] A_CTRL = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;

  typedef struct packed {
    logic                  multi;
    logic [SLOT_IDX_W-1:0] last_slot;
  } rx_cfg_t;

  localparam rx_cfg_t CFG_RESET = '{multi: 1'b1, last_slot: SLOT_IDX_W'(MAX_SLOTS - 1)};
endpackage

// File: rtl/tdm_rx_framer.sv
module tdm_rx_framer
  import tdm_rx_pkg::*;
#(
  parameter int SLOT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_stb,
  input  logic                 fsync,
  input  logic [MAX_SLOTS-1:0] mask_pend,
  input  rx_cfg_t              cfg_pend,
  output logic                 shift_en,
  output logic                 word_done,
  output logic                 slot_keep
);
  localparam int BIT_W = (SLOT_W > 2) ? $clog2(SLOT_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(SLOT_W - 1);

  logic                  active_q, active_d;
  logic [SLOT_IDX_W-1:0] slot_q, slot_d;
  logic [BIT_W-1:0]      bit_q, bit_d;
  logic [MAX_SLOTS-1:0]  mask_q, mask_d;
  rx_cfg_t               cfg_q, cfg_d;
  logic                  start;
  logic                  at_last_bit;
  logic [SLOT_IDX_W-1:0] end_slot;

  always_comb begin
    start       = bit_stb & fsync;
    at_last_bit = (bit_q == LAST_BIT);
    end_slot    = cfg_q.multi ? cfg_q.last_slot : '0;
    shift_en    = bit_stb & (fsync | active_q);
    word_done   = bit_stb & ~fsync & active_q & at_last_bit;
    slot_keep   = mask_q[slot_q];

    active_d = active_q;
    slot_d   = slot_q;
    bit_d    = bit_q;
    mask_d   = mask_q;
    cfg_d    = cfg_q;
    if (start) begin
      active_d = 1'b1;
      slot_d   = '0;
      bit_d    = BIT_W'(1);
      mask_d   = mask_pend;
      cfg_d    = cfg_pend;
    end else if (bit_stb && active_q) begin
      if (at_last_bit) begin
        bit_d = '0;
        if (slot_q == end_slot) active_d = 1'b0;
        else                    slot_d   = slot_q + SLOT_IDX_W'(1);
      end else begin
        bit_d = bit_q + BIT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      slot_q   <= '0;
      bit_q    <= '0;
      mask_q   <= '1;
      cfg_q    <= CFG_RESET;
    end else if (bit_stb) begin
      active_q <= active_d;
      slot_q   <= slot_d;
      bit_q    <= bit_d;
      mask_q   <= mask_d;
      cfg_q    <= cfg_d;
    end
  end

  assert_start_loads_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && fsync) |=> (mask_q == $past(mask_pend)));

  assert_mask_held_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_stb && fsync) |=> $stable(mask_q));

  assert_slot_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (slot_q <= cfg_q.last_slot) || !cfg_q.multi);

  assert_single_slot_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && !cfg_q.multi) |-> (slot_q == '0));

  assert_restart_slot0_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && fsync) |=> (active_q && slot_q == '0));
endmodule

// File: rtl/tdm_rx_deser.sv
module tdm_rx_deser #(
  parameter int SLOT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              sdata,
  output logic [SLOT_W-1:0] word
);
  logic [SLOT_W-2:0] sh_q;
  logic [SLOT_W-2:0] sh_d;

  always_comb begin
    sh_d = {sh_q[SLOT_W-3:0], sdata};
    word = {sh_q, sdata};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sh_q <= '0;
    else if (shift_en) sh_q <= sh_d;
  end

  assert_msb_first_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (sh_q[0] == $past(sdata)));
endmodule

// File: rtl/tdm_rx_regs.sv
module tdm_rx_regs
  import tdm_rx_pkg::*;
#(
  parameter int SLOT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_rd,
  input  logic                 bus_wr,
  input  logic [1:0]           bus_addr,
  input  logic [BUS_W-1:0]     bus_wdata,
  output logic [BUS_W-1:0]     bus_rdata,
  input  logic                 word_done,
  input  logic                 slot_keep,
  input  logic [SLOT_W-1:0]    word,
  output logic [MAX_SLOTS-1:0] mask_pend,
  output rx_cfg_t              cfg_pend,
  output logic                 rx_full,
  output logic                 rx_ovr
);
  logic [MAX_SLOTS-1:0] mask_q, mask_d;
  rx_cfg_t              cfg_q, cfg_d;
  logic [SLOT_W-1:0]    data_q, data_d;
  logic                 full_q, full_d;
  logic                 ovr_q, ovr_d;
  logic                 store, rd_data, rd_stat;

  always_comb begin
    store   = word_done & slot_keep;
    rd_data = bus_rd & (bus_addr == A_DATA);
    rd_stat = bus_rd & (bus_addr == A_STAT);

    mask_d = mask_q;
    cfg_d  = cfg_q;
    if (bus_wr && bus_addr == A_MASK) mask_d = bus_wdata;
    if (bus_wr && bus_addr == A_CTRL) begin
      cfg_d.multi     = bus_wdata[8];
      cfg_d.last_slot = bus_wdata[SLOT_IDX_W-1:0];
    end

    data_d = store ? word : data_q;

    if (store)        full_d = 1'b1;
    else if (rd_data) full_d = 1'b0;
    else              full_d = full_q;

    if (store && full_q && !rd_data) ovr_d = 1'b1;
    else if (rd_stat)                ovr_d = 1'b0;
    else                             ovr_d = ovr_q;

    case (bus_addr)
      A_MASK:  bus_rdata = mask_q;
      A_CTRL:  bus_rdata = {23'd0, cfg_q.multi, 3'd0, cfg_q.last_slot};
      A_DATA:  bus_rdata = BUS_W'(data_q);
      default: bus_rdata = {30'd0, ovr_q, full_q};
    endcase

    mask_pend = mask_q;
    cfg_pend  = cfg_q;
    rx_full   = full_q;
    rx_ovr    = ovr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      cfg_q  <= CFG_RESET;
      data_q <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (bus_wr) begin
        mask_q <= mask_d;
        cfg_q  <= cfg_d;
      end
      if (store) data_q <= data_d;
      full_q <= full_d;
      ovr_q  <= ovr_d;
    end
  end

  assert_full_on_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    store |=> rx_full);

  assert_drop_keeps_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && !slot_keep) |=> ($stable(data_q) && (rx_full == $past(rx_full || 1'b0) || $past(rd_data))));

  assert_read_clears_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !store) |=> !rx_full);

  assert_overrun_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (store && rx_full && !rd_data) |=> rx_ovr);

  assert_no_false_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_ovr && !(store && rx_full)) |=> !rx_ovr);
endmodule

// File: rtl/tdm_rx.sv
module tdm_rx
  import tdm_rx_pkg::*;
#(
  parameter int SLOT_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bit_stb,
  input  logic        fsync,
  input  logic        sdata,
  input  logic        bus_rd,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        rx_full,
  output logic        rx_ovr
);
  logic                 rst_meta_n, rst_sync_n;
  logic                 shift_en, word_done, slot_keep;
  logic [SLOT_W-1:0]    word;
  logic [MAX_SLOTS-1:0] mask_pend;
  rx_cfg_t              cfg_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  tdm_rx_framer #(.SLOT_W(SLOT_W)) u_framer (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bit_stb   (bit_stb),
    .fsync     (fsync),
    .mask_pend (mask_pend),
    .cfg_pend  (cfg_pend),
    .shift_en  (shift_en),
    .word_done (word_done),
    .slot_keep (slot_keep)
  );

  tdm_rx_deser #(.SLOT_W(SLOT_W)) u_deser (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .shift_en (shift_en),
    .sdata    (sdata),
    .word     (word)
  );

  tdm_rx_regs #(.SLOT_W(SLOT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .word_done (word_done),
    .slot_keep (slot_keep),
    .word      (word),
    .mask_pend (mask_pend),
    .cfg_pend  (cfg_pend),
    .rx_full   (rx_full),
    .rx_ovr    (rx_ovr)
  );
endmodule

// File: tb/tdm_rx_bench.sv
module tdm_rx_bench;
  localparam int SW = 8;

  logic        clk, rst_n, bit_stb, fsync, sdata, bus_rd, bus_wr;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        rx_full, rx_ovr;

  int tests, fails, fr;
  logic [31:0] rd, last_word;

  tdm_rx #(.SLOT_W(SW)) u_tdm_rx (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .fsync(fsync), .sdata(sdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rx_full(rx_full), .rx_ovr(rx_ovr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] wv(input int f, input int s);
    return 32'((f * 37 + s * 11 + 5) & ((1 << SW) - 1));
  endfunction

  task automatic send_bit(input logic fs, input logic d);
    @(negedge clk);
    bit_stb = 1'b1; fsync = fs; sdata = d;
    @(negedge clk);
    bit_stb = 1'b0; fsync = 1'b0;
  endtask

  task automatic send_word(input logic first, input logic [31:0] w);
    for (int i = SW - 1; i >= 0; i--) send_bit(first && (i == SW - 1), w[i]);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // after each slot: status must show full==keep, then data check
  task automatic slot_check(input string tag, input logic keep, input logic [31:0] w);
    logic [31:0] st, dv;
    bus_read(2'd3, st);
    chk({tag, " status"}, st, {30'd0, 1'b0, keep});
    bus_read(2'd2, dv);
    if (keep) last_word = w;
    chk({tag, " data"}, dv, last_word);
  endtask

  initial begin
    tests = 0; fails = 0;
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] masks [6];
    rst_n = 1'b0; bit_stb = 1'b0; fsync = 1'b0; sdata = 1'b0;
    bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = 32'd0;
    last_word = 32'd0; fr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset values
    bus_read(2'd0, rd); chk("R1 mask reset", rd, 32'hFFFF_FFFF);
    bus_read(2'd1, rd); chk("R1 ctrl reset", rd, 32'h0000_011F);
    bus_read(2'd2, rd); chk("R1 data reset", rd, 32'd0);
    bus_read(2'd3, rd); chk("R1 status reset", rd, 32'd0);

    // R2 R3 sweep: 4 slots, multi-slot mode
    bus_write(2'd1, 32'h0000_0103);
    masks[0] = 32'hFFFF_FFFF; masks[1] = 32'h5; masks[2] = 32'hA;
    masks[3] = 32'h9;         masks[4] = 32'h0; masks[5] = 32'hE;
    for (int m = 0; m < 6; m++) begin
      bus_write(2'd0, masks[m]);
      fr++;
      for (int s = 0; s < 4; s++) begin
        send_word(s == 0, wv(fr, s));
        slot_check(masks[m][s] ? "R2 kept slot" : "R3 masked slot", masks[m][s], wv(fr, s));
      end
    end

    // R4 R5 mask write mid-frame (active mask 0xE)
    fr++;
    send_word(1'b1, wv(fr, 0));
    slot_check("R4 old mask slot0", 1'b0, 0);
    bus_write(2'd0, 32'h1);
    bus_read(2'd0, rd); chk("R5 mask readback", rd, 32'h1);
    for (int s = 1; s < 4; s++) begin
      send_word(1'b0, wv(fr, s));
      slot_check("R4 old mask rest", 1'b1, wv(fr, s));
    end
    fr++;
    for (int s = 0; s < 4; s++) begin
      send_word(s == 0, wv(fr, s));
      slot_check("R4 new mask", s == 0, wv(fr, s));
    end

    // R11 restart on mid-frame sync, only slot 1 kept
    bus_write(2'd0, 32'h2);
    fr++;
    send_word(1'b1, wv(fr, 0));
    for (int i = 0; i < 3; i++) send_bit(1'b0, 1'b1);
    fr++;
    send_word(1'b1, wv(fr, 0));
    slot_check("R11 restart slot0", 1'b0, 0);
    send_word(1'b0, wv(fr, 1));
    slot_check("R11 restart slot1", 1'b1, wv(fr, 1));

    // R10 R8 control change mid-frame, extra bits ignored
    bus_write(2'd0, 32'hFFFF_FFFF);
    fr++;
    send_word(1'b1, wv(fr, 0));
    slot_check("R10 slot0", 1'b1, wv(fr, 0));
    bus_write(2'd1, 32'h0000_0101);
    for (int s = 1; s < 4; s++) begin
      send_word(1'b0, wv(fr, s));
      slot_check("R10 old count", 1'b1, wv(fr, s));
    end
    send_word(1'b0, wv(fr, 9));
    slot_check("R8 past last slot", 1'b0, 0);
    fr++;
    for (int s = 0; s < 3; s++) begin
      send_word(s == 0, wv(fr, s));
      slot_check("R8 two slots", s < 2, wv(fr, s));
    end

    // R7 overrun, R6 same-cycle read and store
    fr++;
    send_word(1'b1, wv(fr, 0));
    send_word(1'b0, wv(fr, 1));
    bus_read(2'd3, rd); chk("R7 overrun status", rd, 32'h3);
    bus_read(2'd3, rd); chk("R7 status read clears ovr only", rd, 32'h1);
    bus_read(2'd2, rd); chk("R7 newest word kept", rd, wv(fr, 1));
    bus_read(2'd3, rd); chk("R6 data read clears full", rd, 32'h0);
    fr++;
    send_word(1'b1, wv(fr, 0));
    for (int i = SW - 1; i >= 1; i--) send_bit(1'b0, wv(fr, 1) >> i);
    @(negedge clk);
    bit_stb = 1'b1; sdata = wv(fr, 1) & 1; bus_rd = 1'b1; bus_addr = 2'd2;
    #1 rd = bus_rdata;
    @(negedge clk);
    bit_stb = 1'b0; bus_rd = 1'b0;
    chk("R6 coincident read old word", rd, wv(fr, 0));
    bus_read(2'd3, rd); chk("R6 coincident full stays", rd, 32'h1);
    bus_read(2'd2, rd); chk("R6 coincident new word", rd, wv(fr, 1));
    last_word = wv(fr, 1);

    // R9 single-slot mode
    bus_write(2'd1, 32'h0000_0003);
    fr++;
    send_word(1'b1, wv(fr, 0));
    slot_check("R9 single slot0", 1'b1, wv(fr, 0));
    send_word(1'b0, wv(fr, 1));
    slot_check("R9 single slot1 ignored", 1'b0, 0);
    bus_write(2'd0, 32'hFFFF_FFFE);
    fr++;
    send_word(1'b1, wv(fr, 0));
    slot_check("R9 mask bit0 clear", 1'b0, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule